// File: doc/BRIEF.md
# XTS Tweaked Block Encryptor

This block turns one 128-bit plaintext block into ciphertext under the XTS construction with a 256-bit key. The key is made of two 128-bit halves. The tweak half encrypts the caller's 128-bit tweak value. The result is then multiplied by alpha once for each step of the block's position inside its data unit. The resulting mask is XORed into the plaintext, the data half encrypts that value with AES-128, and the same mask is XORed into the result.

A single AES-128 round datapath does all of the work. It computes one round per clock and derives the round keys as it goes. It runs the tweak pass first, then the serial alpha multiply, then the data pass.

The input side uses a valid/ready handshake. `in_ready` is high only while the block is idle, and a request is taken on a clock edge where both `in_valid` and `in_ready` are high. Back-pressure rules: the caller holds its inputs stable while it waits for `in_ready`, and `in_valid` has no effect while the block is busy. The output has no back-pressure. A single-cycle `done` pulse marks the cycle in which new ciphertext appears on `ctext`, and `ctext` then stays unchanged until the next `done`.

Top module: `xts_enc_core`

## Requirements
- R1: While reset (`rst_n` low) is held and after it is released, `in_ready` is 1, `done` is 0 and `ctext` is all zeros.
- R2: A request is accepted on a rising edge where `in_valid` and `in_ready` are both 1. From the cycle after acceptance until the `done` cycle, `in_ready` is 0. In the `done` cycle, `in_ready` is 1 again.
- R3: The mask is T = AES128(key2, tweak) multiplied by alpha to the power `blk_idx`. The tweak key key2 is `key[127:0]`.
- R4: The ciphertext is `ctext` = AES128(key1, `ptext` XOR T) XOR T. The data key key1 is `key[255:128]`.
- R5: Multiplying by alpha treats the 128-bit value as a little-endian number whose byte 0 sits at bits [127:120]. The value is shifted left by one bit. If the bit shifted out was 1, byte 0 is XORed with 0x87.
- R6: All 128-bit vectors (`tweak`, `ptext`, `ctext` and each key half) carry AES byte 0 in bits [127:120] and byte 15 in bits [7:0]. Swapping the two key halves changes the result.
- R7: `done` rises exactly 21 + `blk_idx` clock cycles after the acceptance edge.
- R8: `done` is high for exactly one cycle. `ctext` changes only in a cycle where `done` is high.
- R9: While the block is busy, a high `in_valid` with other inputs produces no second `done` and does not alter the ciphertext of the request being processed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle, request can be taken |
| key | input | 256 | {data key half, tweak key half} |
| tweak | input | 128 | Tweak value for the data unit |
| blk_idx | input | IDX_W | Position of the block inside its data unit |
| ptext | input | 128 | Plaintext block |
| done | output | 1 | One-cycle pulse: new ciphertext valid |
| ctext | output | 128 | Ciphertext, held until next done |

## Verification
An all-zero key, tweak and plaintext with index 0 and with index 1 is compared against known published XTS results. These two cases separate the plain tweak path from a single alpha step taken in the correct direction. A large index with random data forces many carries through the 0x87 reduction. A request with the key halves swapped shows whether each half is used in the right pass. Each result's latency is checked against 21 plus the index, and a request made while the block is busy must leave no trace in the output.

// File: rtl/xts_pkg.sv
package xts_pkg;
  localparam int BLK_W  = 128;
  localparam int NBYTES = BLK_W / 8;
  localparam int ROUNDS = 10;

  typedef enum logic [1:0] {PH_IDLE, PH_TWK, PH_ALPHA, PH_DAT} phase_t;

  // doubling in GF(2^8) with the AES polynomial
  function automatic logic [7:0] xt(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = xt(sh);
    end
    return acc;
  endfunction

  // substitution: inverse as a^254, then affine map
  function automatic logic [7:0] sbox(input logic [7:0] a);
    localparam logic [7:0] EXP = 8'hFE;
    logic [7:0] r;
    logic [7:0] p;
    r = 8'h01;
    p = a;
    for (int i = 0; i < 8; i++) begin
      if (EXP[i]) r = gmul(r, p);
      p = gmul(p, p);
    end
    return r ^ {r[6:0], r[7]} ^ {r[5:0], r[7:6]} ^ {r[4:0], r[7:5]} ^
           {r[3:0], r[7:4]} ^ 8'h63;
  endfunction

  // round constant for round n (1-based)
  function automatic logic [7:0] rcon(input logic [3:0] n);
    logic [7:0] r;
    r = 8'h01;
    for (int i = 1; i < 16; i++) begin
      if (i < int'(n)) r = xt(r);
    end
    return r;
  endfunction
endpackage

// File: rtl/xts_round.sv
module xts_round
  import xts_pkg::*;
#(
  parameter int NB = NBYTES
) (
  input  logic [8*NB-1:0] st_i,
  input  logic [8*NB-1:0] rk_i,
  input  logic            last_i,
  output logic [8*NB-1:0] st_o
);
  localparam int W  = 8 * NB;
  localparam int NC = NB / 4;

  logic [7:0] sb [NB];
  logic [7:0] sh [NB];
  logic [7:0] mx [NB];

  for (genvar k = 0; k < NB; k++) begin : g_sub
    assign sb[k] = sbox(st_i[W-1-8*k -: 8]);
  end

  always_comb begin
    for (int c = 0; c < NC; c++) begin
      for (int r = 0; r < 4; r++) begin
        sh[r + 4*c] = sb[r + 4*((c + r) % NC)];
      end
    end
    for (int c = 0; c < NC; c++) begin
      mx[4*c]   = xt(sh[4*c]) ^ xt(sh[4*c+1]) ^ sh[4*c+1] ^ sh[4*c+2] ^ sh[4*c+3];
      mx[4*c+1] = sh[4*c] ^ xt(sh[4*c+1]) ^ xt(sh[4*c+2]) ^ sh[4*c+2] ^ sh[4*c+3];
      mx[4*c+2] = sh[4*c] ^ sh[4*c+1] ^ xt(sh[4*c+2]) ^ xt(sh[4*c+3]) ^ sh[4*c+3];
      mx[4*c+3] = xt(sh[4*c]) ^ sh[4*c] ^ sh[4*c+1] ^ sh[4*c+2] ^ xt(sh[4*c+3]);
    end
    for (int k = 0; k < NB; k++) begin
      st_o[W-1-8*k -: 8] = (last_i ? sh[k] : mx[k]) ^ rk_i[W-1-8*k -: 8];
    end
  end
endmodule

// File: rtl/xts_keystep.sv
module xts_keystep
  import xts_pkg::*;
#(
  parameter int NW = 4
) (
  input  logic [32*NW-1:0] rk_i,
  input  logic [7:0]       rc_i,
  output logic [32*NW-1:0] rk_o
);
  localparam int W = 32 * NW;

  logic [31:0] rot;
  logic [31:0] sw;
  logic [31:0] tmp;
  logic [31:0] nw [NW];

  assign rot = {rk_i[23:0], rk_i[31:24]};

  for (genvar i = 0; i < 4; i++) begin : g_sw
    assign sw[8*i +: 8] = sbox(rot[8*i +: 8]);
  end

  assign tmp = sw ^ {rc_i, 24'h000000};

  for (genvar i = 0; i < NW; i++) begin : g_word
    if (i == 0) begin : g_first
      assign nw[i] = rk_i[W-1 -: 32] ^ tmp;
    end else begin : g_chain
      assign nw[i] = rk_i[W-1-32*i -: 32] ^ nw[i-1];
    end
    assign rk_o[W-1-32*i -: 32] = nw[i];
  end
endmodule

// File: rtl/xts_alpha.sv
module xts_alpha #(
  parameter int         NB   = 16,
  parameter logic [7:0] POLY = 8'h87
) (
  input  logic [8*NB-1:0] t_i,
  output logic [8*NB-1:0] t_o
);
  localparam int W = 8 * NB;

  logic msb;
  assign msb = t_i[7];  // top bit of little-endian byte NB-1

  for (genvar b = 0; b < NB; b++) begin : g_byte
    if (b == 0) begin : g_low
      assign t_o[W-1 -: 8] = {t_i[W-2 -: 7], 1'b0} ^ (msb ? POLY : 8'h00);
    end else begin : g_up
      assign t_o[W-1-8*b -: 8] = {t_i[W-2-8*b -: 7], t_i[W-1-8*(b-1)]};
    end
  end
endmodule

// File: rtl/xts_enc_core.sv
module xts_enc_core
  import xts_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [2*BLK_W-1:0] key,
  input  logic [BLK_W-1:0]   tweak,
  input  logic [IDX_W-1:0]   blk_idx,
  input  logic [BLK_W-1:0]   ptext,
  output logic               done,
  output logic [BLK_W-1:0]   ctext
);
  localparam int         RND_W = $clog2(ROUNDS + 1);
  localparam logic [RND_W-1:0] LAST_RND = RND_W'(ROUNDS);

  phase_t             phase;
  logic [BLK_W-1:0]   st, rk, tw, k1, pt;
  logic [RND_W-1:0]   rnd;
  logic [IDX_W-1:0]   cnt;
  logic [BLK_W-1:0]   nk, rnd_out, tw_next;
  logic               last;

  assign last     = (rnd == LAST_RND);
  assign in_ready = (phase == PH_IDLE);

  xts_keystep #(.NW(BLK_W/32)) u_key (
    .rk_i (rk),
    .rc_i (rcon(4'(rnd))),
    .rk_o (nk)
  );

  xts_round #(.NB(NBYTES)) u_rnd (
    .st_i   (st),
    .rk_i   (nk),
    .last_i (last),
    .st_o   (rnd_out)
  );

  xts_alpha #(.NB(NBYTES), .POLY(8'h87)) u_alpha (
    .t_i (tw),
    .t_o (tw_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      st    <= '0;
      rk    <= '0;
      tw    <= '0;
      k1    <= '0;
      pt    <= '0;
      rnd   <= '0;
      cnt   <= '0;
      done  <= 1'b0;
      ctext <= '0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (in_valid) begin
            st    <= tweak ^ key[BLK_W-1:0];
            rk    <= key[BLK_W-1:0];
            k1    <= key[2*BLK_W-1:BLK_W];
            pt    <= ptext;
            cnt   <= blk_idx;
            rnd   <= RND_W'(1);
            phase <= PH_TWK;
          end
        end
        PH_TWK: begin
          st  <= rnd_out;
          rk  <= nk;
          rnd <= rnd + 1'b1;
          if (last) begin
            tw    <= rnd_out;
            phase <= PH_ALPHA;
          end
        end
        PH_ALPHA: begin
          if (cnt == '0) begin
            st    <= pt ^ tw ^ k1;
            rk    <= k1;
            rnd   <= RND_W'(1);
            phase <= PH_DAT;
          end else begin
            tw  <= tw_next;
            cnt <= cnt - 1'b1;
          end
        end
        PH_DAT: begin
          st  <= rnd_out;
          rk  <= nk;
          rnd <= rnd + 1'b1;
          if (last) begin
            ctext <= rnd_out ^ tw;
            done  <= 1'b1;
            phase <= PH_IDLE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xts_enc_chk.sv
module xts_enc_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         done,
  input logic [127:0] ctext
);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  ct_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctext) |-> done);

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready);

  // R9
  done_from_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(!in_ready));
endmodule

bind xts_enc_core xts_enc_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .done     (done),
  .ctext    (ctext)
);

// File: tb/xts_enc_core_tb.sv
module xts_enc_core_tb;
  localparam int IDX_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             in_valid;
  logic             in_ready;
  logic [255:0]     key;
  logic [127:0]     tweak;
  logic [IDX_W-1:0] blk_idx;
  logic [127:0]     ptext;
  logic             done;
  logic [127:0]     ctext;

  xts_enc_core #(.IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .key(key), .tweak(tweak), .blk_idx(blk_idx), .ptext(ptext),
    .done(done), .ctext(ctext)
  );

  always #2 clk = ~clk;  // 250 MHz

  int total = 0;
  int fails = 0;
  int cyc = 0;
  int acc_cyc = 0;
  bit finished = 0;
  logic [127:0] exp_q[$];
  int           lat_q[$];
  logic [7:0]   m_sb [256];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p;
    p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011b << (i - 8));
    return p[7:0];
  endfunction

  task automatic build_sbox();
    for (int a = 0; a < 256; a++) begin
      logic [7:0] inv;
      logic [7:0] s;
      inv = 8'h00;
      for (int b = 1; b < 256; b++)
        if (a != 0 && m_mul(8'(a), 8'(b)) == 8'h01) inv = 8'(b);
      for (int i = 0; i < 8; i++)
        s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^
               inv[(i+7)%8] ^ (8'h63 >> i);
      m_sb[a] = s;
    end
  endtask

  function automatic logic [127:0] m_aes(input logic [127:0] k, input logic [127:0] p);
    logic [7:0] w[176];
    logic [7:0] s[16];
    logic [7:0] t[16];
    logic [7:0] a[4];
    logic [7:0] rc;
    logic [127:0] res;
    rc = 8'h01;
    for (int i = 0; i < 16; i++) w[i] = k[127-8*i -: 8];
    for (int i = 4; i < 44; i++) begin
      for (int b = 0; b < 4; b++) a[b] = w[4*(i-1)+b];
      if (i % 4 == 0) begin
        logic [7:0] f;
        f = a[0];
        a[0] = m_sb[a[1]] ^ rc; a[1] = m_sb[a[2]]; a[2] = m_sb[a[3]]; a[3] = m_sb[f];
        rc = m_mul(rc, 8'h02);
      end
      for (int b = 0; b < 4; b++) w[4*i+b] = w[4*(i-4)+b] ^ a[b];
    end
    for (int i = 0; i < 16; i++) s[i] = p[127-8*i -: 8] ^ w[i];
    for (int rr = 1; rr <= 10; rr++) begin
      for (int i = 0; i < 16; i++) t[i] = m_sb[s[i]];
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++) s[r+4*c] = t[r+4*((c+r)%4)];
      if (rr < 10)
        for (int c = 0; c < 4; c++) begin
          for (int b = 0; b < 4; b++) a[b] = s[4*c+b];
          for (int b = 0; b < 4; b++)
            s[4*c+b] = m_mul(a[b], 8'h02) ^ m_mul(a[(b+1)%4], 8'h03) ^
                       a[(b+2)%4] ^ a[(b+3)%4];
        end
      for (int i = 0; i < 16; i++) s[i] = s[i] ^ w[16*rr+i];
    end
    for (int i = 0; i < 16; i++) res[127-8*i -: 8] = s[i];
    return res;
  endfunction

  function automatic logic [127:0] m_mulx(input logic [127:0] v);
    logic [127:0] le;
    logic c;
    logic [127:0] o;
    for (int b = 0; b < 16; b++) le[8*b +: 8] = v[127-8*b -: 8];
    c  = le[127];
    le = le << 1;
    if (c) le[7:0] = le[7:0] ^ 8'h87;
    for (int b = 0; b < 16; b++) o[127-8*b -: 8] = le[8*b +: 8];
    return o;
  endfunction

  function automatic logic [127:0] m_xts(input logic [255:0] k, input logic [127:0] tw,
                                         input int j, input logic [127:0] p);
    logic [127:0] t;
    t = m_aes(k[127:0], tw);
    for (int i = 0; i < j; i++) t = m_mulx(t);
    return m_aes(k[255:128], p ^ t) ^ t;
  endfunction

  // ---------------- driver ----------------
  task automatic send(input logic [255:0] k, input logic [127:0] tw, input int j,
                      input logic [127:0] p, input logic [127:0] exp, input bit poke);
    @(negedge clk);
    in_valid = 1'b1; key = k; tweak = tw; blk_idx = IDX_W'(j); ptext = p;
    wait (in_ready);
    @(posedge clk);
    #1;
    acc_cyc = cyc;
    exp_q.push_back(exp);
    lat_q.push_back(21 + j);
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R2 in_ready low while busy", 128'(in_ready), 128'h0);
    if (poke) begin
      // R9: other request offered while busy
      @(negedge clk);
      in_valid = 1'b1; key = ~k; tweak = ~tw; ptext = ~p; blk_idx = '0;
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        chk(in_ready == 1'b0, "R9 busy request not taken", 128'(in_ready), 128'h0);
      end
      in_valid = 1'b0;
    end
    wait (exp_q.size() == 0);
    repeat (3) @(negedge clk);
  endtask

  // ---------------- monitor ----------------
  logic         prev_done = 1'b0;
  logic [127:0] last_ct = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done)
        chk(done == 1'b0, "R8 done one cycle", 128'(done), 128'h0);
      if (!done && ctext != last_ct)
        chk(1'b0, "R8 ctext held", ctext, last_ct);
      if (done) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 unexpected done", ctext, 128'h0);
        end else begin
          logic [127:0] e;
          int l;
          e = exp_q.pop_front();
          l = lat_q.pop_front();
          chk(ctext == e, "R3 R4 ciphertext", ctext, e);
          chk(cyc - acc_cyc == l, "R7 latency", 128'(cyc - acc_cyc), 128'(l));
        end
      end
      prev_done = done;
      last_ct   = ctext;
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [255:0] k;
    logic [127:0] tw, p;
    rst_n = 1'b0; in_valid = 1'b0; key = '0; tweak = '0; blk_idx = '0; ptext = '0;
    build_sbox();
    repeat (3) @(negedge clk);
    // R1
    chk(in_ready == 1'b1, "R1 reset in_ready", 128'(in_ready), 128'h1);
    chk(done == 1'b0, "R1 reset done", 128'(done), 128'h0);
    chk(ctext == '0, "R1 reset ctext", ctext, 128'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && done == 1'b0, "R1 after release", 128'({in_ready, done}), 128'h2);

    // R3 R4 published all-zero vector, index 0
    send('0, '0, 0, '0, 128'h917cf69ebd68b2ec9b9fe9a3eadda692, 0);
    // R5 same vector, index 1: one alpha step
    send('0, '0, 1, '0, 128'hcd43d2f59598ed858c02c2652fbf922e, 0);

    for (int n = 0; n < 4; n++) begin
      int j;
      k  = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      tw = {$urandom, $urandom, $urandom, $urandom};
      p  = {$urandom, $urandom, $urandom, $urandom};
      j  = (n == 0) ? 0 : (n == 1) ? 3 : (n == 2) ? 200 : 255;  // R5 reduction carries
      send(k, tw, j, p, m_xts(k, tw, j, p), 0);
    end

    // R6 swapped key halves yield the swapped-key result and differ
    k  = {128'h000102030405060708090a0b0c0d0e0f, 128'hf0e1d2c3b4a5968778695a4b3c2d1e0f};
    tw = 128'h00112233445566778899aabbccddeeff;
    p  = 128'h0123456789abcdeffedcba9876543210;
    send(k, tw, 5, p, m_xts(k, tw, 5, p), 0);
    send({k[127:0], k[255:128]}, tw, 5, p, m_xts({k[127:0], k[255:128]}, tw, 5, p), 0);
    chk(m_xts(k, tw, 5, p) != m_xts({k[127:0], k[255:128]}, tw, 5, p),
        "R6 halves distinct", ctext, 128'h0);

    // R9 request offered while busy must be ignored
    k  = {8{32'h5a5aa5a5}};
    send(k, tw, 9, p, m_xts(k, tw, 9, p), 1);
    repeat (40) @(negedge clk);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule